// File: doc/BRIEF.md
# 8-bit ALU Flag Generator

This is a purely combinational arithmetic and logic slice for an 8-bit datapath. It takes two operands, an incoming carry and a 4-bit operation code. It returns the 8-bit result, the Zero, Digit-carry and Carry flag values, and a three-bit write-enable mask. The mask says which of those flags the operation is allowed to change.

A status register outside this block stores the flags. It loads each flag only when its enable is high, and otherwise keeps the old value. Subtraction is built as addition of the two's complement of the second operand. Because of this, Carry and Digit-carry read 1 when no borrow occurs. The two rotates move data through the Carry flag, using the `carry_i` input as the old flag.

Top module: `alu_flag_gen`

## Requirements
- R1: Operation code 0 (add) outputs `res_o = (a_i + b_i) mod 256`. It sets `c_o` to 1 exactly when the 9-bit sum exceeds 255. It asserts all three enables.
- R2: Operation code 1 (subtract) outputs `res_o = (a_i - b_i) mod 256`. `c_o` is 1 when `a_i >= b_i` (no borrow) and 0 when a borrow occurs. It asserts all three enables.
- R3: For add and subtract, `dc_o` is the carry out of bit 3. For add it is 1 when `a_i[3:0] + b_i[3:0] > 15`. For subtract it is 1 when `a_i[3:0] >= b_i[3:0]`.
- R4: Whenever `z_en_o` is 1, `z_o` is 1 exactly when `res_o` is zero.
- R5: The logic operations work as follows, and each asserts `z_en_o` only:
  - code 2 gives `a_i & b_i`
  - code 3 gives `a_i | b_i`
  - code 4 gives `a_i ^ b_i`
  - code 5 gives `~a_i`
  - code 6 gives 0
- R6: Code 7 (rotate right through carry) outputs `res_o = {carry_i, a_i[7:1]}` and `c_o = a_i[0]`. It asserts `c_en_o` only.
- R7: Code 8 (rotate left through carry) outputs `res_o = {a_i[6:0], carry_i}` and `c_o = a_i[7]`. It asserts `c_en_o` only.
- R8: The following codes assert no enable:
  - code 9 swaps the nibbles of `a_i`
  - code 10 passes `a_i`
  - code 11 sets bit `b_i[2:0]` of `a_i`
  - code 12 clears bit `b_i[2:0]` of `a_i`
- R9: A flag output whose enable is 0 is driven to 0.
- R10: Codes 13 to 15 behave as code 10: the result is `a_i` and no flag is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (source register) |
| b_i | input | 8 | Second operand, or bit index in bits [2:0] |
| carry_i | input | 1 | Current carry flag, used by the rotates |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Result |
| z_o | output | 1 | Zero flag value |
| dc_o | output | 1 | Digit-carry flag value |
| c_o | output | 1 | Carry flag value |
| z_en_o | output | 1 | Zero flag may be written |
| dc_en_o | output | 1 | Digit-carry flag may be written |
| c_en_o | output | 1 | Carry flag may be written |

## Verification
The assertions are immediate checks inside combinational blocks. They assume the operands, carry and opcode are all known, so each check is skipped while any input carries X or Z. Each check compares only values computed inside the same block from those inputs, so a partial update of the inputs cannot fire it. The bench drives every input to a known value before its first sample. It changes inputs only between samples, and it waits one time unit after every change before comparing the outputs.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_CLR  = 4'd6,
    OP_RRC  = 4'd7,
    OP_RLC  = 4'd8,
    OP_SWAP = 4'd9,
    OP_MOV  = 4'd10,
    OP_BSET = 4'd11,
    OP_BCLR = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flag_mask_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         dc_o,
  output logic         c_o
);
  localparam int NIB = 4;

  logic [W-1:0]   b_eff;
  logic [W:0]     sum_full;
  logic [NIB:0]   sum_nib;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    sum_full = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_nib  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub_i};
    sum_o    = sum_full[W-1:0];
    c_o      = sum_full[W];
    dc_o     = sum_nib[NIB];

    if (!$isunknown({sub_i, a_i, b_i})) begin
      if (sub_i) begin
        AST_SUB_NO_BORROW: assert (c_o == (a_i >= b_i)) else $error("sub carry"); // R2
        AST_SUB_NIB_BORROW: assert (dc_o == (a_i[NIB-1:0] >= b_i[NIB-1:0])) else $error("sub dc"); // R3
        AST_SUB_RESTORES_A: assert (W'(sum_o + b_i) == a_i) else $error("sub value"); // R2
      end else begin
        AST_ADD_CARRY_OVER: assert (c_o == (a_i > ~b_i)) else $error("add carry"); // R1
        AST_ADD_RESTORES_A: assert (W'(sum_o - b_i) == a_i) else $error("add value"); // R1
      end
    end
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int H  = W / 2;
  localparam int IW = $clog2(W);

  logic [IW-1:0] bit_idx;

  always_comb begin
    bit_idx = b_i[IW-1:0];
    res_o   = a_i;
    c_o     = carry_i;
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~a_i;
      OP_CLR:  res_o = '0;
      OP_RRC: begin
        res_o = {carry_i, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      OP_RLC: begin
        res_o = {a_i[W-2:0], carry_i};
        c_o   = a_i[W-1];
      end
      OP_SWAP: res_o = {a_i[H-1:0], a_i[W-1:H]};
      OP_BSET: res_o[bit_idx] = 1'b1;
      OP_BCLR: res_o[bit_idx] = 1'b0;
      default: res_o = a_i;
    endcase

    if (!$isunknown({op_i, a_i, b_i, carry_i})) begin
      if (op_i == OP_RRC || op_i == OP_RLC)
        AST_ROT_KEEPS_ONES: assert ($countones({c_o, res_o}) == $countones({carry_i, a_i})) else $error("rotate"); // R6
      if (op_i == OP_SWAP)
        AST_SWAP_KEEPS_ONES: assert ($countones(res_o) == $countones(a_i)) else $error("swap"); // R8
      if (op_i == OP_COM)
        AST_COM_DISJOINT: assert ((res_o & a_i) == '0) else $error("complement"); // R5
      if (op_i == OP_BSET)
        AST_BSET_SUPERSET: assert ((res_o & a_i) == a_i) else $error("bit set"); // R8
    end
  end
endmodule

// File: rtl/alu_flag_mask.sv
module alu_flag_mask
  import alu_flag_pkg::*;
(
  input  alu_op_e    op_i,
  output flag_mask_t en_o
);
  always_comb begin
    en_o = '0;
    case (op_i)
      OP_ADD, OP_SUB:                          en_o = '{z: 1'b1, dc: 1'b1, c: 1'b1};
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_CLR:   en_o = '{z: 1'b1, dc: 1'b0, c: 1'b0};
      OP_RRC, OP_RLC:                          en_o = '{z: 1'b0, dc: 1'b0, c: 1'b1};
      default:                                 en_o = '0;
    endcase

    if (!$isunknown(op_i)) begin
      AST_DC_NEEDS_ALL: assert (!en_o.dc || (en_o.c && en_o.z)) else $error("dc mask"); // R3
      AST_HIGH_CODES_QUIET: assert (op_i <= OP_BCLR || en_o == '0) else $error("spare mask"); // R10
    end
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         z_o,
  output logic         dc_o,
  output logic         c_o,
  output logic         z_en_o,
  output logic         dc_en_o,
  output logic         c_en_o
);
  alu_op_e    op;
  flag_mask_t en;
  logic [W-1:0] sum, lres;
  logic         sum_dc, sum_c, lc, is_arith;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu_adder #(.W(W)) u_add (
    .sub_i (op == OP_SUB),
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum),
    .dc_o  (sum_dc),
    .c_o   (sum_c)
  );

  alu_logic_unit #(.W(W)) u_log (
    .op_i    (op),
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .res_o   (lres),
    .c_o     (lc)
  );

  alu_flag_mask u_mask (
    .op_i (op),
    .en_o (en)
  );

  always_comb begin
    res_o   = is_arith ? sum : lres;
    z_en_o  = en.z;
    dc_en_o = en.dc;
    c_en_o  = en.c;
    z_o     = en.z  && (res_o == '0);
    dc_o    = en.dc && sum_dc;
    c_o     = en.c  && (is_arith ? sum_c : lc);
  end
endmodule

// File: tb/sim_alu_flag_gen.sv
module sim_alu_flag_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] a, b, res;
  logic       cin;
  logic [3:0] op;
  logic       z, dc, c, ez, edc, ec;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_gen u0 (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .res_o(res), .z_o(z), .dc_o(dc), .c_o(c),
    .z_en_o(ez), .dc_en_o(edc), .c_en_o(ec)
  );

  // packed view: {res, z, dc, c, ez, edc, ec}
  task automatic chk(input string req, input logic [13:0] exp);
    logic [13:0] act;
    act = {res, z, dc, c, ez, edc, ec};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b actual=%h expected=%h", req, op, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y, input logic ci);
    op = o; a = x; b = y; cin = ci;
    #1;
  endtask

  task automatic t_reset_state;
    apply(4'd10, 8'h00, 8'h00, 1'b0);
    chk("R8", {8'h00, 6'b000000});
  endtask

  task automatic t_add_all;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        int s; logic [7:0] r; logic ec_, edc_;
        apply(4'd0, 8'(i), 8'(j), 1'b0);
        s = i + j; r = 8'(s);
        ec_ = (s > 255); edc_ = ((i & 15) + (j & 15)) > 15;
        chk("R1_R3", {r, r == 8'h00, edc_, ec_, 3'b111});
      end
    end
  endtask

  task automatic t_sub_all;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        logic [7:0] r; logic ec_, edc_;
        apply(4'd1, 8'(i), 8'(j), 1'b1);
        r = 8'(i - j);
        ec_ = (i >= j); edc_ = (i & 15) >= (j & 15);
        chk("R2_R3", {r, r == 8'h00, edc_, ec_, 3'b111});
      end
    end
  endtask

  task automatic t_logic;
    apply(4'd2, 8'hF0, 8'h0F, 1'b1); chk("R5_R4", {8'h00, 3'b100, 3'b100});
    apply(4'd2, 8'hF3, 8'h3C, 1'b0); chk("R5",    {8'h30, 3'b000, 3'b100});
    apply(4'd3, 8'hA0, 8'h05, 1'b1); chk("R5",    {8'hA5, 3'b000, 3'b100});
    apply(4'd3, 8'h00, 8'h00, 1'b1); chk("R5_R4", {8'h00, 3'b100, 3'b100});
    apply(4'd4, 8'h5A, 8'h5A, 1'b0); chk("R5_R4", {8'h00, 3'b100, 3'b100});
    apply(4'd4, 8'h5A, 8'hFF, 1'b0); chk("R5",    {8'hA5, 3'b000, 3'b100});
    apply(4'd5, 8'hFF, 8'h12, 1'b1); chk("R5_R4", {8'h00, 3'b100, 3'b100});
    apply(4'd5, 8'h3C, 8'h00, 1'b0); chk("R5",    {8'hC3, 3'b000, 3'b100});
    apply(4'd6, 8'h77, 8'h99, 1'b1); chk("R5_R9", {8'h00, 3'b100, 3'b100});
  endtask

  task automatic t_rotate;
    apply(4'd7, 8'h01, 8'h00, 1'b0); chk("R6_R9", {8'h00, 3'b001, 3'b001});
    apply(4'd7, 8'h82, 8'h00, 1'b1); chk("R6",    {8'hC1, 3'b000, 3'b001});
    apply(4'd7, 8'hFF, 8'h00, 1'b1); chk("R6",    {8'hFF, 3'b001, 3'b001});
    apply(4'd8, 8'h80, 8'h00, 1'b0); chk("R7_R9", {8'h00, 3'b001, 3'b001});
    apply(4'd8, 8'h41, 8'h00, 1'b1); chk("R7",    {8'h83, 3'b000, 3'b001});
    apply(4'd8, 8'hC0, 8'h00, 1'b1); chk("R7",    {8'h81, 3'b001, 3'b001});
  endtask

  task automatic t_noflag;
    apply(4'd9,  8'h00, 8'h00, 1'b1); chk("R8_R9", {8'h00, 6'b000000});
    apply(4'd9,  8'h3A, 8'h00, 1'b1); chk("R8",    {8'hA3, 6'b000000});
    apply(4'd10, 8'h5C, 8'hFF, 1'b1); chk("R8",    {8'h5C, 6'b000000});
    for (int k = 0; k < 8; k++) begin
      apply(4'd11, 8'h00, 8'(k), 1'b1); chk("R8", {8'(1 << k), 6'b000000});
      apply(4'd12, 8'hFF, 8'(8 + k), 1'b1); chk("R8", {~8'(1 << k), 6'b000000});
    end
    apply(4'd12, 8'h10, 8'h04, 1'b1); chk("R8_R9", {8'h00, 6'b000000});
  endtask

  task automatic t_spare;
    for (int o = 13; o < 16; o++) begin
      apply(4'(o), 8'h96, 8'h33, 1'b1); chk("R10", {8'h96, 6'b000000});
      apply(4'(o), 8'h00, 8'h33, 1'b1); chk("R10", {8'h00, 6'b000000});
    end
  endtask

  initial begin
    op = 4'd10; a = 8'h00; b = 8'h00; cin = 1'b0;
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD / 2 + 1);
    t_reset_state();
    t_logic();
    t_rotate();
    t_noflag();
    t_spare();
    t_add_all();
    t_sub_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule